// File: doc/BRIEF.md
# Two-Level Lookahead Adder-Subtractor with Condition Flags

This block is a purely combinational two's-complement adder and subtractor for 16-bit operands. It is built from 4-bit carry-lookahead groups. Each group forms per-bit generate (A AND B) and propagate (A OR B) terms and computes its internal carries as flat sums of products. Each group also reports a group generate and a group propagate. A second lookahead stage takes these group terms and computes the carry into every group at once, so no carry ripples from one group to the next.

A single select input picks the operation. When it is high, operand B is inverted and the carry-in is forced to 1, so the adder computes A minus B. Alongside the result, the block produces four condition flags: negative, zero, carry and overflow. Any datapath can consume the result and the flags directly in the same cycle.

Top module: `lookahead_addsub`

## Requirements
- R1: With `sub_sel` = 0, `result` equals (`op_a` + `op_b`) modulo 2^16.
- R2: With `sub_sel` = 1, `result` equals (`op_a` - `op_b`) modulo 2^16. The block forms this as `op_a` + ~`op_b` + 1.
- R3: `flag_v` is the XOR of the carry into bit 15 and the carry out of bit 15. It is therefore 1 exactly when the signed result of the selected operation falls outside -32768..32767. For example, 0x7FFF + 0x0001 and 0x8000 - 0x0001 both set it.
- R4: `flag_n` equals bit 15 of `result`.
- R5: `flag_z` is 1 exactly when all 16 bits of `result` are 0.
- R6: `flag_c` is the raw carry out of bit 15 of the adder in both modes. On an add it is 1 when the unsigned sum reaches 65536. On a subtract it is 1 when `op_a` >= `op_b` unsigned, meaning no borrow occurred.
- R7: A carry produced in a low group reaches every higher group through the group lookahead. For example, 0xFFFF + 0x0001 gives `result` 0x0000 with `flag_c` = 1, and 0x0000 - 0x0000 gives 0x0000 with `flag_c` = 1 and `flag_z` = 1.
- R8: When `op_a` and the effective second operand (`op_b`, or ~`op_b` when subtracting) have different bit-15 values, `flag_v` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand; inverted internally when subtracting |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract |
| result | output | 16 | Sum or difference, modulo 2^16 |
| flag_n | output | 1 | Negative: copy of result bit 15 |
| flag_z | output | 1 | Zero: result is all zeros |
| flag_c | output | 1 | Raw carry out of bit 15 |
| flag_v | output | 1 | Signed overflow |

## Verification
The operand patterns each isolate a different failure.

- **Uniform random pairs, both modes:** these cover general arithmetic and flag agreement.
- **Operands forced to share a sign:** overflow can only occur in this case, so these vectors separate a correct overflow path from one that looks only at the result sign.
- **Operands forced to differ in sign:** these confirm that overflow never sets.
- **Long carry chains (all-ones plus one, a nibble of ones crossing a group edge):** these expose a broken group generate, group propagate or lookahead carry term. Ordinary random data rarely reaches these.
- **Directed corners (0x7FFF+1, 0x8000-1, 0-0, A-A):** these pin down overflow direction, the meaning of carry on a subtract, and zero detection.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam int MAXW = 32;

  // Flat sum-of-products carry out of position 'top' given per-position
  // generate and propagate terms and a carry entering position 0.
  function automatic logic flat_carry(input logic [MAXW-1:0] g,
                                      input logic [MAXW-1:0] p,
                                      input int top,
                                      input logic cin);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = -1; j <= top; j++) begin
      term = (j < 0) ? cin : g[j];
      for (int k = j + 1; k <= top; k++) begin
        term = term & p[k];
      end
      acc = acc | term;
    end
    return acc;
  endfunction

  // AND of all propagate terms up to position 'top'.
  function automatic logic chain_prop(input logic [MAXW-1:0] p, input int top);
    logic acc;
    acc = 1'b1;
    for (int k = 0; k <= top; k++) acc = acc & p[k];
    return acc;
  endfunction

endpackage

// File: rtl/cla_group.sv
module cla_group
  import addsub_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          grp_gen,
  output logic          grp_prop,
  output logic          cout_local
);

  logic [MAXW-1:0] gen_w;
  logic [MAXW-1:0] prop_w;
  logic [GW-1:0]   cin_bit;

  always_comb begin
    gen_w  = '0;
    prop_w = '0;
    gen_w[GW-1:0]  = a & b;
    prop_w[GW-1:0] = a | b;
  end

  genvar i;
  generate
    for (i = 0; i < GW; i++) begin : g_bit
      if (i == 0) begin : g_first
        assign cin_bit[i] = cin;
      end else begin : g_rest
        assign cin_bit[i] = flat_carry(gen_w, prop_w, i - 1, cin);
      end
      assign sum[i] = a[i] ^ b[i] ^ cin_bit[i];
    end
  endgenerate

  assign grp_gen    = flat_carry(gen_w, prop_w, GW - 1, 1'b0);
  assign grp_prop   = chain_prop(prop_w, GW - 1);
  assign cout_local = flat_carry(gen_w, prop_w, GW - 1, cin);

  // R7: a generating group must carry out; a killing group must not.
  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      p_gen_forces_carry_r7: assert (!grp_gen || cout_local)
        else $error("group generate without carry out");
      p_kill_blocks_carry_r7: assert (grp_gen || grp_prop || !cout_local)
        else $error("group carry out while killed");
    end
  end

endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit
  import addsub_pkg::*;
#(
  parameter int NG = 4
) (
  input  logic [NG-1:0] grp_gen,
  input  logic [NG-1:0] grp_prop,
  input  logic          cin,
  output logic [NG:0]   grp_carry
);

  logic [MAXW-1:0] gg_w;
  logic [MAXW-1:0] gp_w;

  always_comb begin
    gg_w = '0;
    gp_w = '0;
    gg_w[NG-1:0] = grp_gen;
    gp_w[NG-1:0] = grp_prop;
  end

  assign grp_carry[0] = cin;

  genvar k;
  generate
    for (k = 0; k < NG; k++) begin : g_grp
      assign grp_carry[k+1] = flat_carry(gg_w, gp_w, k, cin);
    end
  endgenerate

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_eff,
  input  logic [W-1:0] res,
  input  logic         carry_out,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);

  logic carry_into_msb;

  // The sum bit is a^b^c, so the carry into the MSB is recovered from it.
  assign carry_into_msb = res[W-1] ^ a[W-1] ^ b_eff[W-1];

  assign flag_n = res[W-1];
  assign flag_z = (res == '0);
  assign flag_c = carry_out;
  assign flag_v = carry_into_msb ^ carry_out;

  always_comb begin
    if (!$isunknown({a, b_eff, carry_out})) begin
      p_zero_not_neg_r5: assert (!flag_z || !flag_n)
        else $error("zero and negative together");
      p_ovf_same_sign_r3: assert (!flag_v || (a[W-1] == b_eff[W-1]))
        else $error("overflow with operands of different sign");
    end
  end

endmodule

// File: rtl/lookahead_addsub.sv
module lookahead_addsub #(
  parameter int WIDTH   = 16,
  parameter int GROUP_W = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_sel,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);

  localparam int NGRP = WIDTH / GROUP_W;

  logic [WIDTH-1:0] b_eff;
  logic [NGRP-1:0]  grp_gen;
  logic [NGRP-1:0]  grp_prop;
  logic [NGRP-1:0]  grp_cout;
  logic [NGRP:0]    grp_carry;

  assign b_eff = op_b ^ {WIDTH{sub_sel}};

  genvar k;
  generate
    for (k = 0; k < NGRP; k++) begin : g_group
      cla_group #(.GW(GROUP_W)) u_grp (
        .a          (op_a [k*GROUP_W +: GROUP_W]),
        .b          (b_eff[k*GROUP_W +: GROUP_W]),
        .cin        (grp_carry[k]),
        .sum        (result[k*GROUP_W +: GROUP_W]),
        .grp_gen    (grp_gen[k]),
        .grp_prop   (grp_prop[k]),
        .cout_local (grp_cout[k])
      );
    end
  endgenerate

  cla_carry_unit #(.NG(NGRP)) u_lookahead (
    .grp_gen   (grp_gen),
    .grp_prop  (grp_prop),
    .cin       (sub_sel),
    .grp_carry (grp_carry)
  );

  addsub_flags #(.W(WIDTH)) u_flags (
    .a         (op_a),
    .b_eff     (b_eff),
    .res       (result),
    .carry_out (grp_carry[NGRP]),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_v    (flag_v)
  );

  always_comb begin
    if (!$isunknown({op_a, op_b, sub_sel})) begin
      for (int g = 0; g < NGRP; g++) begin
        p_group_carry_r7: assert (grp_cout[g] == grp_carry[g+1])
          else $error("lookahead carry disagrees with group carry");
      end
      if (op_a[WIDTH-1] != b_eff[WIDTH-1]) begin
        p_no_overflow_r8: assert (!flag_v)
          else $error("overflow on mixed-sign operands");
      end
      if (sub_sel && (op_a == op_b)) begin
        p_self_sub_r6: assert (flag_z && flag_c)
          else $error("A-A not zero with carry");
      end
    end
  end

endmodule

// File: tb/lookahead_addsub_test.sv
module lookahead_addsub_test;

  logic        clk = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        sub_sel = 1'b0;
  logic [15:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  lookahead_addsub uut (
    .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  function automatic logic [15:0] exp_res(input logic [15:0] a, input logic [15:0] b, input logic s);
    int v;
    v = s ? (int'(a) - int'(b)) : (int'(a) + int'(b));
    return v[15:0];
  endfunction

  function automatic logic exp_c(input logic [15:0] a, input logic [15:0] b, input logic s);
    if (s) return (a >= b);
    return ((int'(a) + int'(b)) > 65535);
  endfunction

  function automatic logic exp_v(input logic [15:0] a, input logic [15:0] b, input logic s);
    int sa, sb, r;
    sa = int'($signed(a));
    sb = int'($signed(b));
    r  = s ? (sa - sb) : (sa + sb);
    return (r > 32767) || (r < -32768);
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (a=%h b=%h sub=%0d)",
               req, what, got, exp, op_a, op_b, sub_sel);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic s);
    logic [15:0] r;
    @(posedge clk);
    op_a = a; op_b = b; sub_sel = s;
    @(negedge clk);
    r = exp_res(a, b, s);
    chk(s ? "R2" : "R1", "result", int'(result), int'(r));
    chk("R4", "flag_n", int'(flag_n), int'(r[15]));
    chk("R5", "flag_z", int'(flag_z), int'(r == 16'h0));
    chk("R6", "flag_c", int'(flag_c), int'(exp_c(a, b, s)));
    chk("R3", "flag_v", int'(flag_v), int'(exp_v(a, b, s)));
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] a, b;
    logic        s;
    void'($urandom(32'h5A17));
    // reset-like idle state: all-zero inputs
    #5;
    chk("R5", "idle flag_z", int'(flag_z), 1);
    chk("R1", "idle result", int'(result), 0);
    // R3 corners: overflow in both directions
    apply(16'h7FFF, 16'h0001, 1'b0);
    chk("R3", "0x7FFF+1 V", int'(flag_v), 1);
    apply(16'h8000, 16'h0001, 1'b1);
    chk("R3", "0x8000-1 V", int'(flag_v), 1);
    chk("R6", "0x8000-1 C", int'(flag_c), 1);
    apply(16'h8000, 16'h8000, 1'b0);
    chk("R3", "neg+neg V", int'(flag_v), 1);
    // R7 carry chains through all groups
    apply(16'hFFFF, 16'h0001, 1'b0);
    chk("R7", "0xFFFF+1 res", int'(result), 0);
    chk("R7", "0xFFFF+1 C", int'(flag_c), 1);
    apply(16'h0000, 16'h0000, 1'b1);
    chk("R7", "0-0 Z", int'(flag_z), 1);
    chk("R7", "0-0 C", int'(flag_c), 1);
    apply(16'h00F8, 16'h0008, 1'b0);
    apply(16'h0FFF, 16'h0001, 1'b0);
    // R6 borrow on subtract
    apply(16'h0001, 16'h0002, 1'b1);
    chk("R6", "1-2 C", int'(flag_c), 0);
    apply(16'h1234, 16'h1234, 1'b1);
    // R8 mixed signs
    apply(16'h7FFF, 16'h8000, 1'b0);
    chk("R8", "mixed add V", int'(flag_v), 0);
    apply(16'h8000, 16'h0000, 1'b1);
    chk("R8", "mixed sub V", int'(flag_v), 0);
    for (int i = 0; i < 3000; i++) begin
      a = 16'($urandom);
      b = 16'($urandom);
      s = 1'($urandom);
      case (i % 4)
        1: b[15] = a[15] ^ s;            // same effective sign
        2: begin
             b[15] = ~(a[15] ^ s);       // differing effective sign
           end
        3: begin
             a = 16'hFFFF >> ($urandom % 16);
             b = s ? 16'hFFFF : 16'h0001;
           end
        default: ;
      endcase
      apply(a, b, s);
      if ((i % 4) == 2) chk("R8", "random mixed V", int'(flag_v), 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule